// File: doc/BRIEF.md
# Sampled Switch Debouncer

This block turns the raw contact signal of a hand-operated toggle switch into one clean level change per physical action. The asynchronous input first passes a two-register synchronizer. A prescaler then produces a sampling strobe once every `TICK_DIV` clocks, which is 10 ms at a 13.5 MHz clock with the default of 135,000.

On each strobe the freshly synchronized sample is compared with the sample taken on the strobe before. A run counter grows while the two agree and is cleared when they disagree. Once the run reaches `MATCH_RUN` agreeing comparisons, the accepted level takes the sampled value and the run starts again from zero.

The accepted level then drives a two-register output stage. That stage lets a new value through only after it has been present on two consecutive clocks, so a spike that lasts one clock cannot reach the pin. The block sits between a switch input pad and whatever logic reacts to the switch position.

Top module: `switch_debouncer`

## Requirements
- R1: While `rst` is high (synchronous, active high), every stage loads the current `sw_raw` level, so `sw_clean` equals the input level present during reset and the run counter is zero.
- R2: The sampling strobe fires exactly once every `TICK_DIV` clocks and never on two consecutive clocks. The first strobe after reset comes on the `TICK_DIV`-th rising edge.
- R3: A change of `sw_raw` that then stays stable appears on `sw_clean` after L rising edges, counted from the first edge that sees the new value. L lies in the window [5 + MATCH_RUN*TICK_DIV, 4 + TICK_DIV + MATCH_RUN*TICK_DIV]. With the defaults, L is about 40 ms.
- R4: A strobe whose sample differs from the previous sample clears the run counter. After an interruption that at least one strobe sees, the R3 window restarts from the moment the input returns to the new level.
- R5: A change of `sw_raw` that lasts no more than MATCH_RUN*TICK_DIV clocks before returning has no effect on `sw_clean`.
- R6: `sw_clean` changes only to a value that the accepted level held on each of the two preceding clocks. A one-clock spike of the accepted level is therefore suppressed, and a lasting change reaches the pin two clocks after acceptance.
- R7: The run counter stays below `MATCH_RUN`. It changes only on a strobe and returns to zero on the strobe that accepts a level.
- R8: The input is synchronized by two registers before it is sampled, and the accepted level changes only on a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_raw | input | 1 | Raw asynchronous switch contact level |
| sw_clean | output | 1 | Debounced, spike-filtered switch level |

## Verification
A prescaler that strobes too often or too rarely moves the latency of every real switch action out of the R3 window, and this is visible on the very first action after reset. A run counter that is not cleared on a disagreeing sample lets an interrupted action through early, or lets a short pulse through at all. That error shows up within one sampling interval of the disturbance. A fault in the output stage or the synchronizer shifts the latency by a clock or two, or passes a short pulse, so the window edges are checked to the exact clock.

// File: rtl/swdb_pkg.sv
package swdb_pkg;

  // Terminal value of the prescaler count for a given division ratio.
  function automatic int unsigned tick_last(input int unsigned div);
    return (div < 2) ? 32'd1 : div - 32'd1;
  endfunction

  // Next run length: grows on agreement, collapses on disagreement.
  function automatic int unsigned run_next(input int unsigned run, input logic same);
    return same ? run + 32'd1 : 32'd0;
  endfunction

  // True when a run of the given length completes the acceptance rule.
  function automatic logic run_complete(input int unsigned run, input int unsigned need);
    return run >= need;
  endfunction

endpackage

// File: rtl/swdb_sync.sv
module swdb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{d_i}};
    else     chain_q <= {chain_q[LAST-1:0], d_i};
  end

  assign q_o = chain_q[LAST];

  // R8
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (chain_q[0] == $past(d_i)));
endmodule

// File: rtl/swdb_tick_gen.sv
module swdb_tick_gen #(
  parameter int TICK_DIV = 135000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  import swdb_pkg::*;

  localparam int CNT_W = (TICK_DIV < 2) ? 1 : $clog2(TICK_DIV);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(tick_last(TICK_DIV));

  logic [CNT_W-1:0] cnt_q;
  logic             wrap_w;

  assign wrap_w = (cnt_q == CNT_LAST);
  assign tick_o = wrap_w;

  always_ff @(posedge clk) begin
    if (rst || wrap_w) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_LAST);
endmodule

// File: rtl/swdb_run_tracker.sv
module swdb_run_tracker #(
  parameter int MATCH_RUN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic init_i,
  input  logic tick_i,
  input  logic samp_i,
  output logic level_o
);
  import swdb_pkg::*;

  localparam int RUN_W = $clog2(MATCH_RUN + 1);

  logic             prev_q;
  logic             level_q;
  logic [RUN_W-1:0] run_q;

  // Named internal events for the checks below
  logic        same_w;
  logic        accept_w;
  int unsigned run_nx_w;

  assign same_w   = (samp_i == prev_q);
  assign run_nx_w = run_next(32'(run_q), same_w);
  assign accept_w = tick_i && run_complete(run_nx_w, MATCH_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= init_i;
      level_q <= init_i;
      run_q   <= '0;
    end else if (tick_i) begin
      prev_q <= samp_i;
      if (accept_w) begin
        level_q <= samp_i;
        run_q   <= '0;
      end else begin
        run_q <= RUN_W'(run_nx_w);
      end
    end
  end

  assign level_o = level_q;

  // R7
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_q < RUN_W'(MATCH_RUN));

  // R7
  run_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(run_q));

  // R4
  run_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !same_w) |=> (run_q == '0));

  // R8
  level_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(level_q));

  // R3
  level_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && accept_w) |=> (level_q == $past(samp_i)) && (run_q == '0));
endmodule

// File: rtl/swdb_spike_filter.sv
module swdb_spike_filter (
  input  logic clk,
  input  logic rst,
  input  logic init_i,
  input  logic d_i,
  output logic q_o
);
  logic stage1_q;
  logic out_q;
  logic agree_w;

  assign agree_w = (stage1_q == d_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= init_i;
      out_q    <= init_i;
    end else begin
      stage1_q <= d_i;
      if (agree_w) out_q <= d_i;
    end
  end

  assign q_o = out_q;

  // R6
  spike_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (out_q != $past(out_q))) |->
      ($past(stage1_q) == out_q) && ($past(d_i) == out_q));
endmodule

// File: rtl/switch_debouncer.sv
module switch_debouncer #(
  parameter int TICK_DIV    = 135000,
  parameter int MATCH_RUN   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_raw,
  output logic sw_clean
);
  logic synced_w;
  logic tick_w;
  logic level_w;

  swdb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (sw_raw),
    .q_o (synced_w)
  );

  swdb_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick_w)
  );

  swdb_run_tracker #(.MATCH_RUN(MATCH_RUN)) u_track (
    .clk     (clk),
    .rst     (rst),
    .init_i  (sw_raw),
    .tick_i  (tick_w),
    .samp_i  (synced_w),
    .level_o (level_w)
  );

  swdb_spike_filter u_filt (
    .clk    (clk),
    .rst    (rst),
    .init_i (sw_raw),
    .d_i    (level_w),
    .q_o    (sw_clean)
  );

  // R1
  reset_level_chk: assert property (@(posedge clk)
    rst |=> (sw_clean == $past(sw_raw)));
endmodule

// File: tb/test_switch_debouncer.sv
module test_switch_debouncer;
  localparam int A_DIV = 4;
  localparam int A_RUN = 4;
  localparam int B_DIV = 8;
  localparam int B_RUN = 2;
  localparam int A_LO = 5 + A_RUN * A_DIV;
  localparam int A_HI = 4 + A_DIV + A_RUN * A_DIV;
  localparam int B_LO = 5 + B_RUN * B_DIV;
  localparam int B_HI = 4 + B_DIV + B_RUN * B_DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_raw = 1'b0;
  logic a_out;
  logic b_out;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  switch_debouncer #(.TICK_DIV(A_DIV), .MATCH_RUN(A_RUN)) i_switch_debouncer (
    .clk(clk), .rst(rst), .sw_raw(sw_raw), .sw_clean(a_out));

  switch_debouncer #(.TICK_DIV(B_DIV), .MATCH_RUN(B_RUN)) i_switch_debouncer_b (
    .clk(clk), .rst(rst), .sw_raw(sw_raw), .sw_clean(b_out));

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_range(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic do_reset(logic lvl);
    @(negedge clk);
    sw_raw = lvl;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_bit("R1 reset level a", a_out, lvl);
    check_bit("R1 reset level b", b_out, lvl);
  endtask

  // Counts edges until each output shows the target; -1 when it never does.
  task automatic measure(logic target, output int la, output int lb);
    la = -1;
    lb = -1;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (la < 0 && a_out === target) la = k;
      if (lb < 0 && b_out === target) lb = k;
    end
  endtask

  task automatic hold_still(string req, logic exp, int n);
    int bad_a = 0;
    int bad_b = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (a_out !== exp) bad_a++;
      if (b_out !== exp) bad_b++;
    end
    check_range({req, " a stray cycles"}, bad_a, 0, 0);
    check_range({req, " b stray cycles"}, bad_b, 0, 0);
  endtask

  task automatic t_reset;
    do_reset(1'b1);
    hold_still("R1 stable high after reset", 1'b1, 40);
    do_reset(1'b0);
    hold_still("R1 stable low after reset", 1'b0, 40);
  endtask

  task automatic t_rise_fall;
    int la, lb;
    do_reset(1'b0);
    sw_raw = 1'b1;
    measure(1'b1, la, lb);
    check_range("R3 R8 rise latency a", la, A_LO, A_HI);
    check_range("R3 R8 rise latency b", lb, B_LO, B_HI);
    @(negedge clk);
    sw_raw = 1'b0;
    measure(1'b0, la, lb);
    check_range("R3 R2 fall latency a", la, A_LO, A_HI);
    check_range("R3 R2 fall latency b", lb, B_LO, B_HI);
  endtask

  task automatic t_short_pulses;
    do_reset(1'b0);
    repeat (30) @(negedge clk);
    sw_raw = 1'b1;
    repeat (A_RUN * A_DIV) @(negedge clk);
    sw_raw = 1'b0;
    hold_still("R5 pulse of run length", 1'b0, 60);
    sw_raw = 1'b1;
    @(negedge clk);
    sw_raw = 1'b0;
    hold_still("R5 R6 one clock glitch", 1'b0, 60);
  endtask

  task automatic t_bounce;
    int la, lb;
    do_reset(1'b0);
    for (int i = 0; i < 11; i++) begin
      sw_raw = ~sw_raw;
      repeat (2) @(negedge clk);
    end
    sw_raw = 1'b1;
    measure(1'b1, la, lb);
    check_range("R3 settles after bounce a", la, 1, A_HI);
    check_range("R3 settles after bounce b", lb, 1, B_HI);
  endtask

  task automatic t_dip;
    int la, lb;
    do_reset(1'b0);
    sw_raw = 1'b1;
    repeat (10) @(negedge clk);
    check_bit("R4 no early accept a", a_out, 1'b0);
    check_bit("R4 no early accept b", b_out, 1'b0);
    sw_raw = 1'b0;
    repeat (8) @(negedge clk);
    sw_raw = 1'b1;
    measure(1'b1, la, lb);
    check_range("R4 restart after dip a", la, A_LO, A_HI);
    check_range("R4 restart after dip b", lb, B_LO, B_HI);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_rise_fall();
    t_short_pulses();
    t_bounce();
    t_dip();
    finish_run();
  end
endmodule